// File: doc/BRIEF.md
# Dual-Channel PLL Lock Monitor with Lock-Pin Selector

This block watches two synthesizer loops and decides, for each, whether the loop is locked. Each loop provides two divider outputs: a reference divider output and a channel (feedback) divider output. Both are synchronous to the oscillator clock. The block finds the rising edge of each output and measures how many oscillator cycles separate the two edges. A loop counts as locked once that separation has stayed inside a small window for enough consecutive comparisons. One failed comparison drops the lock at once.

A single lock-pin output is driven by a selector. In normal operation the selector shows one channel's status, the other channel's status, their AND, or a constant low. A channel in standby always presents a good status, so in normal mode its effect on the pin is high. In test mode the same selector routes internal probe signals to the pin instead. These probes are prescaler outputs, divider outputs, and divided copies of the oscillator clock. The standby bits pick which group of probes is routed.

The window width and the number of consecutive good comparisons are parameters. Their defaults are 2 oscillator cycles and 4 comparisons.

Top module: `pll_lock_monitor`

## Requirements
- R1: After synchronous reset both channels are unlocked. With test_i=0, no standby, and {ld1_i,ld2_i}=11, ld_o is 0.
- R2: A comparison passes when the partner rising edge arrives 0 or 1 oscillator cycles after the first edge. A channel reports lock once 4 consecutive comparisons have passed. The status rises right after the clock edge that samples the 4th passing partner edge.
- R3: After only 3 consecutive passing comparisons, the channel still reports unlocked.
- R4: A comparison fails when the partner edge is 2 or more cycles late, or missing. The lock is dropped right after the edge that samples offset 2. It is still held at offsets 0 and 1. After a failure, 4 new passing comparisons are needed to regain lock.
- R5: The edge offset is measured in either order, whether the channel divider edge or the reference edge comes first.
- R6: A channel in standby (sb1_i for channel 1, sb2_i for channel 2) presents status high. Standby also clears that channel's lock history.
- R7: With test_i=0, {ld1_i,ld2_i} selects the pin source: 00 gives 0, 01 gives channel 2 status, 10 gives channel 1 status, and 11 gives channel 1 AND channel 2.
- R8: With test_i=0 and both channels in standby, selector 00 gives 0 and every other selector value gives 1.
- R9: Test mode with sb1_i=1 and sb2_i=0 selects probe group A. In group A, selector 00 gives 0, 01 gives pres2_i, 10 gives div2_i, and 11 gives ref2_i.
- R10: Test mode with sb1_i=0 and sb2_i=1 selects probe group B. In group B, selector 00 gives the oscillator divided by 4, 01 gives pres1_i, 10 gives div1_i, and 11 gives the oscillator divided by 2. After m clock edges out of reset, the divide-by-2 probe equals bit 0 of m and the divide-by-4 probe equals bit 1 of m.
- R11: In test mode, sb1_i equal to sb2_i drives ld_o to 0 whatever the selector and the probes are.
- R12: The two channels are independent: failures on one channel leave the other channel's lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref1_i | input | 1 | Reference divider output for channel 1 |
| div1_i | input | 1 | Channel 1 divider output |
| ref2_i | input | 1 | Reference divider output for channel 2 |
| div2_i | input | 1 | Channel 2 divider output |
| pres1_i | input | 1 | Channel 1 prescaler output (test probe) |
| pres2_i | input | 1 | Channel 2 prescaler output (test probe) |
| test_i | input | 1 | Test mode enable |
| sb1_i | input | 1 | Channel 1 standby |
| sb2_i | input | 1 | Channel 2 standby |
| ld1_i | input | 1 | Selector upper bit |
| ld2_i | input | 1 | Selector lower bit |
| ld_o | output | 1 | Lock-detect pin level |

## Verification
The hardest situation to reach is a lock dropping at exactly the edge that closes the window. To get there, the bench first builds a full run of good comparisons on a channel. It then sends a lone reference pulse and samples the pin on three successive cycles, expecting high, high, then low. Offsets of exactly 1 and exactly 2 are driven in both edge orders to pin down the window boundary. A stray partner pulse afterwards returns the edge tracker to idle before the next run. The history clearing on standby is only visible by leaving standby and counting afresh, so the bench does exactly that.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,
        DET_WAIT = 2'd1,
        DET_LATE = 2'd2
    } det_state_e;

    // sel[1] is ld1_i, sel[0] is ld2_i
    typedef struct packed {
        logic       test;
        logic       sb1;
        logic       sb2;
        logic [1:0] sel;
    } ld_ctrl_t;

    typedef struct packed {
        logic pres1;
        logic pres2;
        logic div1;
        logic div2;
        logic refc;
        logic tap2;
        logic tap4;
    } probe_t;

    // opts = {v11, v10, v01, v00}
    function automatic logic pick4(input logic [1:0] s, input logic [3:0] opts);
        return opts[s];
    endfunction

endpackage

// File: rtl/phase_window_det.sv
module phase_window_det
    import lockdet_pkg::*;
#(
    parameter int WIN_CYC   = 2,
    parameter int LOCK_RUNS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic ref_in,
    input  logic div_in,
    output logic locked,
    output logic pass,
    output logic fail
);
    localparam int GW = $clog2(WIN_CYC + 1);
    localparam int RW = $clog2(LOCK_RUNS + 1);
    localparam logic [GW-1:0] GAP_LIM = GW'(WIN_CYC);
    localparam logic [GW-1:0] GAP_ONE = GW'(1);
    localparam logic [RW-1:0] RUN_LIM = RW'(LOCK_RUNS);

    logic ref_q, div_q, ref_rise, div_rise;
    logic lead_ref, lead_ref_n, partner, same;
    det_state_e st, st_n;
    logic [GW-1:0] gap, gap_n;
    logic [RW-1:0] runs, runs_n;

    assign ref_rise = ref_in & ~ref_q;
    assign div_rise = div_in & ~div_q;
    assign partner  = lead_ref ? div_rise : ref_rise;
    assign same     = lead_ref ? ref_rise : div_rise;

    // edge pairing and window judgement
    always_comb begin
        st_n       = st;
        gap_n      = gap;
        lead_ref_n = lead_ref;
        pass       = 1'b0;
        fail       = 1'b0;
        if (standby) begin
            st_n = DET_IDLE;
        end else begin
            case (st)
                DET_WAIT: begin
                    if (partner) begin
                        if (gap < GAP_LIM) pass = 1'b1;
                        else               fail = 1'b1;
                        st_n = DET_IDLE;
                    end else if (same) begin
                        fail  = 1'b1;
                        gap_n = GAP_ONE;
                    end else if (gap >= GAP_LIM) begin
                        fail = 1'b1;
                        st_n = DET_LATE;
                    end else begin
                        gap_n = gap + GAP_ONE;
                    end
                end
                DET_LATE: begin
                    if (same) begin
                        st_n  = DET_WAIT;
                        gap_n = GAP_ONE;
                    end else if (partner) begin
                        st_n = DET_IDLE;
                    end
                end
                default: begin
                    if (ref_rise && div_rise) begin
                        pass = 1'b1;
                    end else if (ref_rise || div_rise) begin
                        st_n       = DET_WAIT;
                        gap_n      = GAP_ONE;
                        lead_ref_n = ref_rise;
                    end
                end
            endcase
        end
    end

    // consecutive good-comparison run, saturating
    always_comb begin
        runs_n = runs;
        if (standby || fail)
            runs_n = '0;
        else if (pass && runs != RUN_LIM)
            runs_n = runs + RW'(1);
    end

    assign locked = (runs == RUN_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q    <= 1'b0;
            div_q    <= 1'b0;
            st       <= DET_IDLE;
            gap      <= '0;
            lead_ref <= 1'b0;
            runs     <= '0;
        end else begin
            ref_q    <= ref_in;
            div_q    <= div_in;
            st       <= st_n;
            gap      <= gap_n;
            lead_ref <= lead_ref_n;
            runs     <= runs_n;
        end
    end

endmodule

// File: rtl/osc_taps.sv
module osc_taps (
    input  logic clk,
    input  logic rst,
    output logic tap2,
    output logic tap4
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tap2 <= 1'b0;
            tap4 <= 1'b0;
        end else begin
            tap2 <= ~tap2;
            if (tap2) tap4 <= ~tap4;
        end
    end
endmodule

// File: rtl/ld_out_mux.sv
module ld_out_mux
    import lockdet_pkg::*;
(
    input  ld_ctrl_t       ctrl,
    input  logic [NCH-1:0] chan_ok,
    input  probe_t         probe,
    output logic           ld
);
    always_comb begin
        if (!ctrl.test)
            ld = pick4(ctrl.sel, {chan_ok[0] & chan_ok[1], chan_ok[0], chan_ok[1], 1'b0});
        else if (ctrl.sb1 && !ctrl.sb2)
            ld = pick4(ctrl.sel, {probe.refc, probe.div2, probe.pres2, 1'b0});
        else if (!ctrl.sb1 && ctrl.sb2)
            ld = pick4(ctrl.sel, {probe.tap2, probe.div1, probe.pres1, probe.tap4});
        else
            ld = 1'b0;
    end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import lockdet_pkg::*;
#(
    parameter int WIN_CYC   = 2,
    parameter int LOCK_RUNS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref1_i,
    input  logic div1_i,
    input  logic ref2_i,
    input  logic div2_i,
    input  logic pres1_i,
    input  logic pres2_i,
    input  logic test_i,
    input  logic sb1_i,
    input  logic sb2_i,
    input  logic ld1_i,
    input  logic ld2_i,
    output logic ld_o
);
    logic [NCH-1:0] ref_v, div_v, sb_v;
    logic [NCH-1:0] locked_v, pass_v, fail_v, chan_ok;
    logic tap2, tap4;
    ld_ctrl_t ctrl;
    probe_t   probe;

    assign ref_v = {ref2_i, ref1_i};
    assign div_v = {div2_i, div1_i};
    assign sb_v  = {sb2_i, sb1_i};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        phase_window_det #(
            .WIN_CYC  (WIN_CYC),
            .LOCK_RUNS(LOCK_RUNS)
        ) u_det (
            .clk    (clk),
            .rst    (rst),
            .standby(sb_v[g]),
            .ref_in (ref_v[g]),
            .div_in (div_v[g]),
            .locked (locked_v[g]),
            .pass   (pass_v[g]),
            .fail   (fail_v[g])
        );
        assign chan_ok[g] = sb_v[g] | locked_v[g];
    end

    osc_taps u_taps (
        .clk (clk),
        .rst (rst),
        .tap2(tap2),
        .tap4(tap4)
    );

    assign ctrl  = '{test: test_i, sb1: sb1_i, sb2: sb2_i, sel: {ld1_i, ld2_i}};
    assign probe = '{pres1: pres1_i, pres2: pres2_i, div1: div1_i, div2: div2_i,
                     refc: ref2_i, tap2: tap2, tap4: tap4};

    ld_out_mux u_mux (
        .ctrl   (ctrl),
        .chan_ok(chan_ok),
        .probe  (probe),
        .ld     (ld_o)
    );

endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       test_i,
    input logic       sb1_i,
    input logic       sb2_i,
    input logic       ld1_i,
    input logic       ld2_i,
    input logic       ld_o,
    input logic [1:0] sb_v,
    input logic [1:0] locked_v,
    input logic [1:0] pass_v,
    input logic [1:0] fail_v,
    input logic       tap2,
    input logic       tap4
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    p_fail_drop_ch1_r4: assert property (@(posedge clk) disable iff (rst)
        fail_v[0] |=> !locked_v[0]);
    p_fail_drop_ch2_r4: assert property (@(posedge clk) disable iff (rst)
        fail_v[1] |=> !locked_v[1]);
    p_lock_after_pass_ch1_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_v[0]) |-> $past(pass_v[0]));
    p_lock_after_pass_ch2_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_v[1]) |-> $past(pass_v[1]));
    p_standby_clear_ch1_r6: assert property (@(posedge clk) disable iff (rst)
        sb_v[0] |=> !locked_v[0]);
    p_standby_clear_ch2_r6: assert property (@(posedge clk) disable iff (rst)
        sb_v[1] |=> !locked_v[1]);
    p_sel_low_r7: assert property (@(posedge clk) disable iff (rst)
        (!test_i && !ld1_i && !ld2_i) |-> !ld_o);
    p_test_off_low_r11: assert property (@(posedge clk) disable iff (rst)
        (test_i && (sb1_i == sb2_i)) |-> !ld_o);
    p_tap2_toggle_r10: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (tap2 != $past(tap2)));
    p_tap4_step_r10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(tap2)) |-> (tap4 != $past(tap4)));
    p_tap4_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(tap2)) |-> $stable(tap4));
endmodule

bind pll_lock_monitor pll_lock_monitor_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .test_i  (test_i),
    .sb1_i   (sb1_i),
    .sb2_i   (sb2_i),
    .ld1_i   (ld1_i),
    .ld2_i   (ld2_i),
    .ld_o    (ld_o),
    .sb_v    (sb_v),
    .locked_v(locked_v),
    .pass_v  (pass_v),
    .fail_v  (fail_v),
    .tap2    (tap2),
    .tap4    (tap4)
);

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int FRAME = 8;
    localparam int RUNS  = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, ref1, div1, ref2, div2, pres1, pres2, test, sb1, sb2, ld1, ld2, ld;
    int checks = 0, errors = 0, ncyc = 0, runs1 = 0, runs2 = 0;
    bit done = 0;

    typedef struct { logic exp; string tag; } item_t;
    item_t q[$];

    pll_lock_monitor u_dut (
        .clk(clk), .rst(rst), .ref1_i(ref1), .div1_i(div1), .ref2_i(ref2), .div2_i(div2),
        .pres1_i(pres1), .pres2_i(pres2), .test_i(test), .sb1_i(sb1), .sb2_i(sb2),
        .ld1_i(ld1), .ld2_i(ld2), .ld_o(ld)
    );

    always @(posedge clk) ncyc <= rst ? 0 : ncyc + 1;

    // monitor: compare queued expectations with the pin
    initial forever begin
        @(posedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (ld !== it.exp) begin
                errors++;
                $display("FAIL %s: ld_o actual %b expected %b", it.tag, ld, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #0.5;
    endtask

    task automatic expect_ld(logic e, string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic setp(int ch, logic r, logic d);
        if (ch == 1) begin ref1 = r; div1 = d; end
        else         begin ref2 = r; div2 = d; end
    endtask

    task automatic set_sel(logic a, logic b);
        @(negedge clk);
        ld1 = a;
        ld2 = b;
        step();
    endtask

    // one comparison on a channel; off = partner delay in cycles
    task automatic frame(int ch, int off, bit ref_first);
        for (int c = 0; c < FRAME; c++) begin
            logic a, b;
            @(negedge clk);
            a = (c == 0);
            b = (c == off);
            if (ref_first) setp(ch, a, b);
            else           setp(ch, b, a);
            step();
        end
        if (ch == 1) runs1 = (off < 2) ? ((runs1 < RUNS) ? runs1 + 1 : RUNS) : 0;
        else         runs2 = (off < 2) ? ((runs2 < RUNS) ? runs2 + 1 : RUNS) : 0;
    endtask

    function automatic logic lk(int ch);
        return (ch == 1) ? (runs1 >= RUNS) : (runs2 >= RUNS);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung run, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; ref1 = 0; div1 = 0; ref2 = 0; div2 = 0; pres1 = 0; pres2 = 0;
        test = 0; sb1 = 0; sb2 = 0; ld1 = 1; ld2 = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        step();
        expect_ld(1'b0, "R1 reset AND select");
        set_sel(1, 0);
        expect_ld(1'b0, "R1 reset ch1 select");

        // R3 then R2: aligned edges
        for (int i = 0; i < 3; i++) begin
            frame(1, 0, 1);
            expect_ld(lk(1), "R3 three good runs not enough");
        end
        frame(1, 0, 1);
        expect_ld(lk(1), "R2 lock after fourth run");

        // R4: drop exactly at offset 2
        @(negedge clk) ref1 = 1;
        step();
        expect_ld(1'b1, "R4 held at offset 0");
        @(negedge clk) ref1 = 0;
        step();
        expect_ld(1'b1, "R4 held at offset 1");
        step();
        expect_ld(1'b0, "R4 dropped at offset 2");
        runs1 = 0;
        @(negedge clk) div1 = 1;
        step();
        @(negedge clk) div1 = 0;
        step();

        // R2 boundary offset 1
        for (int i = 0; i < 4; i++) begin
            frame(1, 1, 1);
            expect_ld(lk(1), "R2 offset 1 passes");
        end
        frame(1, 2, 1);
        expect_ld(lk(1), "R4 offset 2 fails");

        // R5: divider edge first
        for (int i = 0; i < 4; i++) begin
            frame(1, 1, 0);
            expect_ld(lk(1), "R5 divider-first lock");
        end
        frame(1, 3, 0);
        expect_ld(lk(1), "R5 divider-first late fails");
        for (int i = 0; i < 4; i++) frame(1, 0, 0);
        expect_ld(lk(1), "R5 relock");

        // R12: failures on ch2 leave ch1 alone
        frame(2, 2, 1);
        frame(2, 3, 0);
        expect_ld(lk(1), "R12 ch1 kept during ch2 faults");
        for (int i = 0; i < 4; i++) frame(2, 1, 1);
        set_sel(0, 1);
        expect_ld(lk(2), "R12 ch2 locked");

        // R7 selector
        set_sel(0, 0);
        expect_ld(1'b0, "R7 sel 00");
        set_sel(1, 1);
        expect_ld(lk(1) & lk(2), "R7 sel 11 both locked");
        frame(2, 3, 1);
        expect_ld(lk(1) & lk(2), "R7 sel 11 ch2 unlocked");
        set_sel(1, 0);
        expect_ld(lk(1), "R7 sel 10");
        set_sel(0, 1);
        expect_ld(lk(2), "R7 sel 01");

        // R6 standby high and history cleared
        @(negedge clk) sb2 = 1;
        step();
        expect_ld(1'b1, "R6 ch2 standby high");
        set_sel(1, 1);
        expect_ld(lk(1), "R6 standby counts high in AND");
        @(negedge clk) begin sb2 = 0; ld1 = 1; ld2 = 0; end
        step();
        @(negedge clk) sb1 = 1;
        step();
        step();
        @(negedge clk) sb1 = 0;
        runs1 = 0;
        step();
        expect_ld(1'b0, "R6 history cleared");
        for (int i = 0; i < 3; i++) frame(1, 0, 1);
        expect_ld(lk(1), "R6 three runs after standby");
        frame(1, 0, 1);
        expect_ld(lk(1), "R6 relock after standby");

        // R8 both channels in standby
        @(negedge clk) begin sb1 = 1; sb2 = 1; end
        step();
        runs1 = 0;
        runs2 = 0;
        for (int s = 0; s < 4; s++) begin
            set_sel(s[1], s[0]);
            expect_ld(s != 0, "R8 both standby");
        end

        // R9 group A
        @(negedge clk) begin test = 1; sb1 = 1; sb2 = 0; pres1 = 1; div1 = 1; end
        step();
        set_sel(0, 0);
        expect_ld(1'b0, "R9 group A sel 00");
        set_sel(0, 1);
        @(negedge clk) pres2 = 1;
        step();
        expect_ld(1'b1, "R9 pres2 high");
        @(negedge clk) pres2 = 0;
        step();
        expect_ld(1'b0, "R9 pres2 low");
        set_sel(1, 0);
        @(negedge clk) div2 = 1;
        step();
        expect_ld(1'b1, "R9 div2 high");
        @(negedge clk) div2 = 0;
        step();
        expect_ld(1'b0, "R9 div2 low");
        set_sel(1, 1);
        @(negedge clk) ref2 = 1;
        step();
        expect_ld(1'b1, "R9 ref2 high");
        @(negedge clk) ref2 = 0;
        step();
        expect_ld(1'b0, "R9 ref2 low");

        // R10 group B
        @(negedge clk) begin sb1 = 0; sb2 = 1; pres1 = 0; div1 = 0; ld1 = 0; ld2 = 1; end
        step();
        @(negedge clk) pres1 = 1;
        step();
        expect_ld(1'b1, "R10 pres1 high");
        @(negedge clk) pres1 = 0;
        step();
        expect_ld(1'b0, "R10 pres1 low");
        set_sel(1, 0);
        @(negedge clk) div1 = 1;
        step();
        expect_ld(1'b1, "R10 div1 high");
        @(negedge clk) div1 = 0;
        step();
        expect_ld(1'b0, "R10 div1 low");
        set_sel(1, 1);
        for (int i = 0; i < 4; i++) begin
            step();
            expect_ld(ncyc[0], "R10 osc divided by 2");
        end
        set_sel(0, 0);
        for (int i = 0; i < 6; i++) begin
            step();
            expect_ld(ncyc[1], "R10 osc divided by 4");
        end

        // R11 other standby combinations in test mode
        @(negedge clk) begin pres1 = 1; pres2 = 1; div1 = 1; div2 = 1; ref2 = 1; end
        for (int c = 0; c < 2; c++) begin
            @(negedge clk) begin sb1 = c[0]; sb2 = c[0]; end
            for (int s = 0; s < 4; s++) begin
                set_sel(s[1], s[0]);
                expect_ld(1'b0, "R11 test mode forced low");
            end
        end

        step();
        step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule